// File: doc/BRIEF.md
# USB Endpoint Ping-Pong Buffer Manager

This block owns the packet storage of a full-speed USB device controller with four endpoints. Endpoint 0 is a bidirectional control endpoint with one packet buffer. Endpoint 1 receives data (OUT) and has two packet buffers. Endpoint 2 sends data (IN) and also has two packet buffers. Endpoint 3 sends data and has one buffer. Every buffer holds 64 bytes, so the storage is 384 bytes. Each buffer has an owner, either the CPU or the USB engine. It also has a byte count from 0 to 64. Only the owner may fill or drain a buffer.

The CPU reaches the buffer it currently holds on an endpoint by giving an endpoint number and a byte offset. It gives a buffer to the USB side by arming it. On an IN endpoint, arming states the packet length. On the OUT endpoint, arming offers an empty buffer for reception. The USB side is a byte-stream packet interface. A token asks for an IN or OUT transfer, and the block answers one cycle later with accept or NAK. Accepted IN packets stream out byte by byte and wait for a handshake. Accepted OUT packets stream in and end with a good/bad indication. On the double-buffered endpoints, the CPU side and the USB side each keep their own toggling pointer. This lets the CPU work on one packet while the USB side moves the other. Bulk and interrupt transfers are handled the same way.

Top module: `usb_epbuf_mgr`

## Requirements
- R1: Each of the six 64-byte buffers keeps its contents independently. Traffic on one endpoint never changes a byte held in another endpoint's buffer.
- R2: After reset, every buffer is CPU-owned (`cpu_avail` = 4'b1111) and every byte count is 0.
- R3: A CPU write lands in the buffer the CPU currently holds on `cpu_ep`, at `cpu_off`. `cpu_rdata` shows the addressed byte one cycle after the address. A write while that buffer is USB-owned has no effect.
- R4: An arm is legal for endpoint 0 in either direction, for endpoint 1 only as OUT (`cpu_arm_in`=0), and for endpoints 2 and 3 only as IN. An illegal arm is ignored, and so is an arm while the CPU-side buffer is USB-owned. An IN arm length above 64 is clamped to 64.
- R5: A token in idle gets `usb_rsp_valid` in the next cycle. `usb_rsp_nak`=1 when the endpoint's USB-side buffer is not USB-owned or the direction does not match. An accepted IN streams exactly the armed number of bytes from offset 0 upward, with `usb_tx_last` on the final byte.
- R6: After an IN packet, `usb_hs_ack` returns the buffer to the CPU and advances the USB-side pointer. `usb_hs_lost` keeps the buffer USB-owned, so the next IN token resends the same bytes.
- R7: An accepted OUT packet stores `usb_rx_valid` bytes from offset 0 upward. Bytes past 64 are dropped and the count stops at 64. An OUT token with no USB-owned buffer free is NAKed.
- R8: `usb_rx_end` with `usb_rx_ok`=1 gives the buffer to the CPU with its byte count, shown on `cpu_len`. With `usb_rx_ok`=0 the buffer stays USB-owned for the next packet.
- R9: On endpoints 1 and 2, two buffers can be armed at once. They are used by the USB side in the order they were armed, and `cpu_avail` drops only when both are USB-owned.
- R10: `irq` is high exactly when some endpoint has both its `cpu_avail` bit and its `irq_en` bit set.
- R11: Endpoint 0 takes the direction of its last arm. A token of the other direction is NAKed.
- R12: On the single-buffered endpoint 3, a second arm while the first packet is pending is ignored. The pending length is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_ep | input | 2 | Endpoint addressed by CPU data access and `cpu_len` |
| cpu_off | input | 6 | Byte offset inside the CPU-held buffer |
| cpu_we | input | 1 | CPU byte write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Byte at `cpu_ep`/`cpu_off`, one cycle late |
| cpu_len | output | 7 | Byte count of the CPU-side buffer of `cpu_ep` |
| cpu_avail | output | 4 | Per endpoint: CPU-side buffer is CPU-owned |
| cpu_arm | input | 1 | Hand CPU-side buffer to USB |
| cpu_arm_ep | input | 2 | Endpoint to arm |
| cpu_arm_in | input | 1 | 1 = IN packet, 0 = OUT reception |
| cpu_arm_len | input | 7 | IN packet length |
| irq_en | input | 4 | Per-endpoint interrupt enable |
| irq | output | 1 | Service request |
| usb_tok_valid | input | 1 | Token strobe |
| usb_tok_ep | input | 2 | Token endpoint |
| usb_tok_in | input | 1 | 1 = IN token, 0 = OUT token |
| usb_rsp_valid | output | 1 | Token answer strobe |
| usb_rsp_nak | output | 1 | Answer is NAK |
| usb_tx_valid | output | 1 | IN byte valid |
| usb_tx_data | output | 8 | IN byte |
| usb_tx_last | output | 1 | Final IN byte |
| usb_hs_ack | input | 1 | Host acknowledged IN packet |
| usb_hs_lost | input | 1 | IN packet not acknowledged |
| usb_rx_valid | input | 1 | OUT byte valid |
| usb_rx_data | input | 8 | OUT byte |
| usb_rx_end | input | 1 | OUT packet end (no data this cycle) |
| usb_rx_ok | input | 1 | OUT packet good, with `usb_rx_end` |

## Verification
The hardest state to reach is a double-buffered endpoint where the two pointers sit on different buffers. On endpoint 1, the stimulus arms both buffers and then receives two packets, so that a third token finds nothing free and is NAKed. The CPU then releases only the first buffer. A bad packet and then a good one go into that buffer while the second still holds 64 bytes from an over-long packet. This shows the pointers advance independently and a failed packet leaves ownership where it was. Endpoint 2 covers the IN side the same way: two armed packets with different lengths come out in order.

// File: rtl/usb_epbuf_pkg.sv
// Shared definitions for the endpoint buffer manager.
// Assumes four endpoints and six equal packet buffers placed back to back.
package usb_epbuf_pkg;

    localparam int NUM_EP  = 4;
    localparam int NUM_BUF = 6;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_TX      = 2'd1,
        SQ_WAIT_HS = 2'd2,
        SQ_RX      = 2'd3
    } seq_state_t;

    // First byte address of buffer sel of endpoint ep, in ascending layout.
    function automatic int unsigned buf_base(input logic [1:0] ep, input logic sel,
                                             input int unsigned pkt);
        case (ep)
            2'd0:    buf_base = 0;
            2'd1:    buf_base = sel ? 2 * pkt : pkt;
            2'd2:    buf_base = sel ? 4 * pkt : 3 * pkt;
            default: buf_base = 5 * pkt;
        endcase
    endfunction

endpackage

// File: rtl/epbuf_ram.sv
// Byte storage for all endpoint buffers, one CPU port and one USB port.
// Assumes the two ports never write the same address in one cycle, which
// the ownership rules guarantee. Reads are registered (one cycle).
module epbuf_ram #(
    parameter int DEPTH = 384,
    parameter int AW    = 9,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Write both ports and register both read words.
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end

endmodule

// File: rtl/epbuf_ep_ctl.sv
// Ownership, byte counts and ping-pong pointers of one endpoint.
// Assumes arm_go only when the CPU-side buffer is CPU-owned and done_go
// only when the USB-side buffer is USB-owned; the top validates both.
// A single-buffered endpoint keeps both pointers at 0, slot 1 stays idle.
module epbuf_ep_ctl #(
    parameter int PKT     = 64,
    parameter int LW      = 7,
    parameter bit DOUBLE  = 1'b0,
    parameter bit DIR_RST = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_go,
    input  logic          arm_in,
    input  logic [LW-1:0] arm_len,
    input  logic          done_go,
    input  logic          done_out,
    input  logic [LW-1:0] done_len,
    output logic          cpu_ptr,
    output logic          usb_ptr,
    output logic          cpu_side_usb,
    output logic          usb_side_usb,
    output logic          dir_in,
    output logic [LW-1:0] cpu_len,
    output logic [LW-1:0] usb_len
);

    localparam logic [LW-1:0] PKT_L = LW'(PKT);

    logic [1:0]    own;        // 1 = USB owns the slot
    logic [LW-1:0] len_q [2];
    logic          cptr, uptr;
    logic [LW-1:0] arm_len_c;

    // Clamp an armed IN length to one packet.
    always_comb arm_len_c = (arm_len > PKT_L) ? PKT_L : arm_len;

    // Hand buffers over and advance pointers on arm and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own      <= 2'b00;
            len_q[0] <= '0;
            len_q[1] <= '0;
            cptr     <= 1'b0;
            uptr     <= 1'b0;
            dir_in   <= DIR_RST;
        end else begin
            if (done_go) begin
                own[uptr] <= 1'b0;
                if (done_out) len_q[uptr] <= done_len;
                if (DOUBLE) uptr <= ~uptr;
            end
            if (arm_go) begin
                own[cptr]   <= 1'b1;
                len_q[cptr] <= arm_in ? arm_len_c : '0;
                dir_in      <= arm_in;
                if (DOUBLE) cptr <= ~cptr;
            end
        end
    end

    // Expose the state of each side's current slot.
    always_comb begin
        cpu_ptr      = cptr;
        usb_ptr      = uptr;
        cpu_side_usb = own[cptr];
        usb_side_usb = own[uptr];
        cpu_len      = len_q[cptr];
        usb_len      = len_q[uptr];
    end

    AST_ARM_ON_CPU_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        arm_go |-> !own[cptr]) else $error("arm on USB-owned buffer"); // R4
    AST_ARM_HANDS_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        arm_go |=> usb_side_usb) else $error("arm left USB side empty"); // R9
    AST_DONE_ON_USB_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        done_go |-> own[uptr]) else $error("completion on CPU buffer"); // R6
    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q[0] <= PKT_L) && (len_q[1] <= PKT_L)) else $error("count over packet"); // R7

endmodule

// File: rtl/usb_epbuf_mgr.sv
// Endpoint buffer manager: maps CPU accesses and USB packet streams onto
// six fixed buffers and runs the per-transfer sequencer on the USB side.
// Assumes tokens are offered only when the USB engine is ready; tokens
// outside the idle state are not answered.
module usb_epbuf_mgr
    import usb_epbuf_pkg::*;
#(
    parameter int PKT_BYTES = 64,
    parameter int OFF_W     = $clog2(PKT_BYTES),
    parameter int LEN_W     = $clog2(PKT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cpu_ep,
    input  logic [OFF_W-1:0] cpu_off,
    input  logic             cpu_we,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    output logic [LEN_W-1:0] cpu_len,
    output logic [3:0]       cpu_avail,
    input  logic             cpu_arm,
    input  logic [1:0]       cpu_arm_ep,
    input  logic             cpu_arm_in,
    input  logic [LEN_W-1:0] cpu_arm_len,
    input  logic [3:0]       irq_en,
    output logic             irq,
    input  logic             usb_tok_valid,
    input  logic [1:0]       usb_tok_ep,
    input  logic             usb_tok_in,
    output logic             usb_rsp_valid,
    output logic             usb_rsp_nak,
    output logic             usb_tx_valid,
    output logic [7:0]       usb_tx_data,
    output logic             usb_tx_last,
    input  logic             usb_hs_ack,
    input  logic             usb_hs_lost,
    input  logic             usb_rx_valid,
    input  logic [7:0]       usb_rx_data,
    input  logic             usb_rx_end,
    input  logic             usb_rx_ok
);

    localparam int DEPTH = NUM_BUF * PKT_BYTES;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [LEN_W-1:0] PKT_L = LEN_W'(PKT_BYTES);

    logic [NUM_EP-1:0] ep_cptr, ep_uptr, ep_cown_usb, ep_uown_usb, ep_dir;
    logic [NUM_EP-1:0] arm_vec, done_vec;
    logic [LEN_W-1:0]  ep_clen [NUM_EP];
    logic [LEN_W-1:0]  ep_ulen [NUM_EP];

    logic              arm_legal, arm_ok, cpu_we_go;
    logic [AW-1:0]     cpu_addr, usb_addr;

    seq_state_t        st;
    logic [1:0]        cur_ep;
    logic              cur_sel;
    logic [LEN_W-1:0]  cur_len, idx;
    logic              pv, plast, rsp_v, rsp_n;
    logic              tok_ok, tx_issue, rx_wr, done_go, done_out;

    // Check arm direction against the endpoint's capability and ownership.
    always_comb begin
        case (cpu_arm_ep)
            2'd0:    arm_legal = 1'b1;
            2'd1:    arm_legal = !cpu_arm_in;
            default: arm_legal = cpu_arm_in;
        endcase
        arm_ok  = cpu_arm && arm_legal && !ep_cown_usb[cpu_arm_ep];
        arm_vec = arm_ok ? (4'b0001 << cpu_arm_ep) : 4'b0000;
    end

    // Map CPU accesses onto the buffer the CPU holds; block writes otherwise.
    always_comb begin
        cpu_addr  = AW'(buf_base(cpu_ep, ep_cptr[cpu_ep], PKT_BYTES)) + AW'(cpu_off);
        cpu_we_go = cpu_we && !ep_cown_usb[cpu_ep];
        cpu_len   = ep_clen[cpu_ep];
        cpu_avail = ~ep_cown_usb;
        irq       = |(~ep_cown_usb & irq_en);
    end

    // Decide token acceptance and USB-side memory traffic.
    always_comb begin
        tok_ok   = ep_uown_usb[usb_tok_ep] && (ep_dir[usb_tok_ep] == usb_tok_in);
        usb_addr = AW'(buf_base(cur_ep, cur_sel, PKT_BYTES)) + AW'(idx);
        tx_issue = (st == SQ_TX) && (idx < cur_len);
        rx_wr    = (st == SQ_RX) && usb_rx_valid && !usb_rx_end && (idx < PKT_L);
        done_go  = ((st == SQ_WAIT_HS) && usb_hs_ack) ||
                   ((st == SQ_RX) && usb_rx_end && usb_rx_ok);
        done_out = (st == SQ_RX);
        done_vec = done_go ? (4'b0001 << cur_ep) : 4'b0000;
    end

    // Run the USB transfer sequencer: answer, stream, wait, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            cur_ep  <= 2'd0;
            cur_sel <= 1'b0;
            cur_len <= '0;
            idx     <= '0;
            pv      <= 1'b0;
            plast   <= 1'b0;
            rsp_v   <= 1'b0;
            rsp_n   <= 1'b0;
        end else begin
            rsp_v <= 1'b0;
            pv    <= tx_issue;
            plast <= tx_issue && (idx == cur_len - LEN_W'(1));
            case (st)
                SQ_IDLE: if (usb_tok_valid) begin
                    rsp_v   <= 1'b1;
                    rsp_n   <= !tok_ok;
                    cur_ep  <= usb_tok_ep;
                    cur_sel <= ep_uptr[usb_tok_ep];
                    cur_len <= ep_ulen[usb_tok_ep];
                    idx     <= '0;
                    if (tok_ok) st <= usb_tok_in ? SQ_TX : SQ_RX;
                end
                SQ_TX: begin
                    if (tx_issue) idx <= idx + LEN_W'(1);
                    else          st  <= SQ_WAIT_HS;
                end
                SQ_WAIT_HS: if (usb_hs_ack || usb_hs_lost) st <= SQ_IDLE;
                SQ_RX: begin
                    if (usb_rx_end) st  <= SQ_IDLE;
                    else if (rx_wr) idx <= idx + LEN_W'(1);
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        usb_rsp_valid = rsp_v;
        usb_rsp_nak   = rsp_n;
        usb_tx_valid  = pv;
        usb_tx_last   = plast;
    end

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        epbuf_ep_ctl #(
            .PKT    (PKT_BYTES),
            .LW     (LEN_W),
            .DOUBLE ((g == 1) || (g == 2)),
            .DIR_RST(g >= 2)
        ) u_ctl (
            .clk         (clk),
            .rst_n       (rst_n),
            .arm_go      (arm_vec[g]),
            .arm_in      (cpu_arm_in),
            .arm_len     (cpu_arm_len),
            .done_go     (done_vec[g]),
            .done_out    (done_out),
            .done_len    (idx),
            .cpu_ptr     (ep_cptr[g]),
            .usb_ptr     (ep_uptr[g]),
            .cpu_side_usb(ep_cown_usb[g]),
            .usb_side_usb(ep_uown_usb[g]),
            .dir_in      (ep_dir[g]),
            .cpu_len     (ep_clen[g]),
            .usb_len     (ep_ulen[g])
        );
    end

    epbuf_ram #(.DEPTH(DEPTH), .AW(AW), .DW(8)) u_ram (
        .clk    (clk),
        .a_we   (cpu_we_go),
        .a_addr (cpu_addr),
        .a_wdata(cpu_wdata),
        .a_rdata(cpu_rdata),
        .b_we   (rx_wr),
        .b_addr (usb_addr),
        .b_wdata(usb_rx_data),
        .b_rdata(usb_tx_data)
    );

    AST_RSP_AFTER_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == SQ_IDLE) && usb_tok_valid) |=> usb_rsp_valid) else $error("token unanswered"); // R5
    AST_NAK_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_rsp_valid && usb_rsp_nak) |=> !usb_tx_valid) else $error("data after NAK"); // R5
    AST_LAST_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        usb_tx_last |-> usb_tx_valid) else $error("last flag without byte"); // R5
    AST_ONE_COMPLETION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_vec)) else $error("two completions at once"); // R9

endmodule

// File: tb/sim_usb_epbuf_mgr.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_usb_epbuf_mgr;

    localparam int PKT = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cpu_ep = 2'd0;
    logic [5:0] cpu_off = 6'd0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic [6:0] cpu_len;
    logic [3:0] cpu_avail;
    logic       cpu_arm = 1'b0;
    logic [1:0] cpu_arm_ep = 2'd0;
    logic       cpu_arm_in = 1'b0;
    logic [6:0] cpu_arm_len = 7'd0;
    logic [3:0] irq_en = 4'd0;
    logic       irq;
    logic       usb_tok_valid = 1'b0;
    logic [1:0] usb_tok_ep = 2'd0;
    logic       usb_tok_in = 1'b0;
    logic       usb_rsp_valid, usb_rsp_nak;
    logic       usb_tx_valid, usb_tx_last;
    logic [7:0] usb_tx_data;
    logic       usb_hs_ack = 1'b0, usb_hs_lost = 1'b0;
    logic       usb_rx_valid = 1'b0;
    logic [7:0] usb_rx_data = 8'd0;
    logic       usb_rx_end = 1'b0, usb_rx_ok = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    int         tx_cnt = 0;
    int         last_pos = -1;
    logic [7:0] tx_mem [256];

    always #2 clk = ~clk;

    usb_epbuf_mgr u0 (.*);

    // Record every IN byte away from the active edge.
    always @(negedge clk) begin
        if (usb_tx_valid) begin
            tx_mem[tx_cnt % 256] <= usb_tx_data;
            if (usb_tx_last) last_pos <= tx_cnt;
            tx_cnt <= tx_cnt + 1;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] ep, input int off, input logic [7:0] d);
        cpu_ep = ep; cpu_off = 6'(off); cpu_wdata = d; cpu_we = 1'b1;
        tick();
        cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] ep, input int off, output logic [7:0] d);
        cpu_ep = ep; cpu_off = 6'(off);
        tick();
        d = cpu_rdata;
    endtask

    task automatic fill(input logic [1:0] ep, input int n, input logic [7:0] v0);
        for (int i = 0; i < n; i++) cpu_write(ep, i, v0 + 8'(i));
    endtask

    task automatic arm(input logic [1:0] ep, input logic in_dir, input logic [6:0] len);
        cpu_arm = 1'b1; cpu_arm_ep = ep; cpu_arm_in = in_dir; cpu_arm_len = len;
        tick();
        cpu_arm = 1'b0;
    endtask

    task automatic hs(input logic ack);
        usb_hs_ack = ack; usb_hs_lost = !ack;
        tick();
        usb_hs_ack = 1'b0; usb_hs_lost = 1'b0;
    endtask

    // IN token; expect NAK or n bytes counting up from v0.
    task automatic in_xfer(input string req, input logic [1:0] ep, input logic exp_nak,
                           input int n, input logic [7:0] v0);
        int start;
        start = tx_cnt;
        usb_tok_valid = 1'b1; usb_tok_ep = ep; usb_tok_in = 1'b1;
        tick();
        usb_tok_valid = 1'b0;
        check({req, " rsp_valid"}, int'(usb_rsp_valid), 1);
        check({req, " rsp_nak"}, int'(usb_rsp_nak), int'(exp_nak));
        repeat (PKT + 4) tick();
        check({req, " byte count"}, tx_cnt - start, exp_nak ? 0 : n);
        if (!exp_nak && n > 0) begin
            for (int i = 0; i < n; i++)
                check({req, " byte"}, int'(tx_mem[(start + i) % 256]), int'(v0 + 8'(i)));
            check({req, " last position"}, last_pos, start + n - 1);
        end
    endtask

    // OUT token; if accepted, stream n bytes from v0 and end with ok.
    task automatic out_xfer(input string req, input logic [1:0] ep, input logic exp_nak,
                            input int n, input logic [7:0] v0, input logic ok);
        usb_tok_valid = 1'b1; usb_tok_ep = ep; usb_tok_in = 1'b0;
        tick();
        usb_tok_valid = 1'b0;
        check({req, " rsp_valid"}, int'(usb_rsp_valid), 1);
        check({req, " rsp_nak"}, int'(usb_rsp_nak), int'(exp_nak));
        if (!exp_nak) begin
            for (int i = 0; i < n; i++) begin
                usb_rx_valid = 1'b1; usb_rx_data = v0 + 8'(i);
                tick();
            end
            usb_rx_valid = 1'b0;
            usb_rx_end = 1'b1; usb_rx_ok = ok;
            tick();
            usb_rx_end = 1'b0; usb_rx_ok = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R2 avail after reset", int'(cpu_avail), 4'b1111);
        cpu_ep = 2'd2; #1;
        check("R2 count after reset", int'(cpu_len), 0);
        check("R10 irq masked", int'(irq), 0);
        irq_en = 4'b0100; #1;
        check("R10 irq enabled", int'(irq), 1);
        irq_en = 4'b0000; #1;
        check("R10 irq cleared", int'(irq), 0);
    endtask

    task automatic t_cpu_port();
        logic [7:0] d;
        cpu_write(2'd0, 5, 8'h5A);
        cpu_read(2'd0, 5, d);
        check("R3 read after write", int'(d), 8'h5A);
    endtask

    task automatic t_single_in();
        logic [7:0] d;
        fill(2'd3, 5, 8'h30);
        cpu_write(2'd3, 63, 8'hEE);
        arm(2'd3, 1'b1, 7'd5);
        check("R12 ep3 handed over", int'(cpu_avail[3]), 0);
        cpu_write(2'd3, 0, 8'hFF);
        cpu_read(2'd3, 0, d);
        check("R3 write to USB buffer ignored", int'(d), 8'h30);
        arm(2'd3, 1'b1, 7'd9);
        in_xfer("R5/R12 ep3 send", 2'd3, 1'b0, 5, 8'h30);
        hs(1'b0);
        check("R6 lost keeps USB", int'(cpu_avail[3]), 0);
        in_xfer("R6 ep3 resend", 2'd3, 1'b0, 5, 8'h30);
        hs(1'b1);
        check("R6 ack returns buffer", int'(cpu_avail[3]), 1);
        in_xfer("R5 ep3 nak when CPU owns", 2'd3, 1'b1, 0, 8'h00);
    endtask

    task automatic t_wrong_dir();
        out_xfer("R5 OUT on IN endpoint", 2'd2, 1'b1, 0, 8'h00, 1'b0);
        in_xfer("R5 IN on OUT endpoint", 2'd1, 1'b1, 0, 8'h00);
        arm(2'd1, 1'b1, 7'd4);
        check("R4 illegal arm ignored", int'(cpu_avail[1]), 1);
        arm(2'd3, 1'b0, 7'd4);
        check("R4 illegal OUT arm ep3", int'(cpu_avail[3]), 1);
    endtask

    task automatic t_ping_in();
        fill(2'd2, 3, 8'h50);
        arm(2'd2, 1'b1, 7'd3);
        check("R9 one buffer still free", int'(cpu_avail[2]), 1);
        fill(2'd2, 4, 8'h60);
        arm(2'd2, 1'b1, 7'd4);
        check("R9 both buffers armed", int'(cpu_avail[2]), 0);
        in_xfer("R9 first packet", 2'd2, 1'b0, 3, 8'h50);
        hs(1'b1);
        check("R9 buffer back", int'(cpu_avail[2]), 1);
        in_xfer("R9 second packet", 2'd2, 1'b0, 4, 8'h60);
        hs(1'b1);
        fill(2'd2, 64, 8'h80);
        arm(2'd2, 1'b1, 7'd100);
        in_xfer("R4 length clamp", 2'd2, 1'b0, 64, 8'h80);
        hs(1'b1);
    endtask

    task automatic t_out();
        logic [7:0] d;
        out_xfer("R7 nak before arm", 2'd1, 1'b1, 0, 8'h00, 1'b0);
        arm(2'd1, 1'b0, 7'd0);
        arm(2'd1, 1'b0, 7'd0);
        check("R9 ep1 both armed", int'(cpu_avail[1]), 0);
        out_xfer("R7 packet A", 2'd1, 1'b0, 3, 8'hA0, 1'b1);
        out_xfer("R7 packet B", 2'd1, 1'b0, 70, 8'hB0, 1'b1);
        out_xfer("R9 third nak", 2'd1, 1'b1, 0, 8'h00, 1'b0);
        cpu_ep = 2'd1; #1;
        check("R8 count A", int'(cpu_len), 3);
        for (int i = 0; i < 3; i++) begin
            cpu_read(2'd1, i, d);
            check("R8 data A", int'(d), int'(8'hA0 + 8'(i)));
        end
        arm(2'd1, 1'b0, 7'd0);
        cpu_ep = 2'd1; #1;
        check("R7 count saturates", int'(cpu_len), 64);
        cpu_read(2'd1, 63, d);
        check("R7 byte 63 kept", int'(d), 8'hEF);
        out_xfer("R8 bad packet", 2'd1, 1'b0, 5, 8'hC0, 1'b0);
        out_xfer("R8 retry after bad", 2'd1, 1'b0, 2, 8'hD0, 1'b1);
        arm(2'd1, 1'b0, 7'd0);
        cpu_ep = 2'd1; #1;
        check("R8 good packet count", int'(cpu_len), 2);
        cpu_read(2'd1, 0, d);
        check("R8 good packet data", int'(d), 8'hD0);
    endtask

    task automatic t_ep0();
        logic [7:0] d;
        arm(2'd0, 1'b0, 7'd0);
        in_xfer("R11 IN nak while OUT", 2'd0, 1'b1, 0, 8'h00);
        out_xfer("R11 OUT accepted", 2'd0, 1'b0, 2, 8'h11, 1'b1);
        cpu_ep = 2'd0; #1;
        check("R11 ep0 count", int'(cpu_len), 2);
        cpu_read(2'd0, 1, d);
        check("R11 ep0 data", int'(d), 8'h12);
        cpu_write(2'd0, 0, 8'h77);
        arm(2'd0, 1'b1, 7'd1);
        out_xfer("R11 OUT nak while IN", 2'd0, 1'b1, 0, 8'h00, 1'b0);
        in_xfer("R11 IN accepted", 2'd0, 1'b0, 1, 8'h77);
        hs(1'b1);
    endtask

    task automatic t_isolation();
        logic [7:0] d;
        cpu_read(2'd3, 63, d);
        check("R1 ep3 tail untouched", int'(d), 8'hEE);
        cpu_read(2'd3, 0, d);
        check("R1 ep3 head untouched", int'(d), 8'h30);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_cpu_port();
        t_single_in();
        t_wrong_dir();
        t_ping_in();
        t_out();
        t_ep0();
        t_isolation();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule